// File: doc/BRIEF.md
# Dual-Channel Three-Wire Serial Register Slave

This block is the configuration port of a two-channel converter. An external host reaches it over three wires: a serial clock, an active-low chip select and one shared data line. On the chip the data line is split into an input, an output and an output enable. Each transaction opens with a 16-bit instruction that gives the direction, the burst length and a 13-bit start address. One or more data bytes follow, and the address steps up by one after each byte. Every byte travels most significant bit first.

Each channel has its own small bank of 8-bit registers, and the converter core reads those banks from flat output buses. A steering register at address 0 decides which banks take write data. At reset it selects both banks, so one write configures both channels at once. Reads always come from channel A. The serial pins are oversampled by the system clock through synchronizers, so SCLK must run well below the system clock rate.

Top module: `dual_chan_spi_regs`

## Requirements
- R1: After reset the output enable is low, every bank register is 0x00, and the steering register holds 2'b11.
- R2: While chip select is low, the slave takes one bit on each SCLK rising edge, most significant bit first. The 16-bit instruction is laid out as bit 15 = direction (1 = read, 0 = write), bits 14:13 = length code, bits 12:0 = start address.
- R3: While both steering bits are set, a written byte at bank address k (1..NUM_REGS) lands in both banks. Address k appears on `regFileA`/`regFileB` bits [(k-1)*8 +: 8].
- R4: The steering register lives at address 0. Bit 0 enables bank A and bit 1 enables bank B. A write to it always takes effect, whatever the current steering, and reading it returns {6'b0, steering}. A bank whose bit is clear keeps its contents during writes.
- R5: Data bytes within one transaction go to the start address, then the start address plus 1, and so on.
- R6: Length code 00, 01 or 10 limits the transaction to 1, 2 or 3 data bytes, and any further bytes are ignored. Code 11 keeps transferring bytes until chip select rises.
- R7: Read data always comes from bank A. Addresses above NUM_REGS (other than 0) read as 0x00.
- R8: During a read, the output enable rises on the first SCLK falling edge after the last address bit. Each bit is presented after a falling edge, MSB first. The enable stays high until chip select rises and is low afterwards.
- R9: When chip select rises mid-byte or mid-instruction, the partial bits are dropped and no register changes.
- R10: Writes to addresses 1 above NUM_REGS and higher (other than address 0) change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| sdioIn | input | 1 | Data line as seen at the pad input |
| sdioOut | output | 1 | Data the slave drives during reads |
| sdioOe | output | 1 | Pad output enable for the data line |
| regFileA | output | NUM_REGS*8 | Bank A register contents, address k at bits [(k-1)*8 +: 8] |
| regFileB | output | NUM_REGS*8 | Bank B register contents, same layout |

## Verification
A bit counter that drifts by one shows up on the first read as a byte shifted by one position. The scoreboard catches this within eight SCLK periods of the enable rising. A wrong steering mask or a wrong address step shows on the bank buses a few system clocks after the byte that caused it, and the bench compares every register of both banks after each transaction. A length decode that is off by one leaves an extra register written, or a wanted one unwritten, so it is caught at the next bank compare. A chip select that fails to reset the state machine either leaves the enable high after the transaction or changes a register from partial bits, both of which are checked straight after chip select rises.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  localparam int ADDR_W  = 13;
  localparam int DATA_W  = 8;
  localparam int INSTR_W = 16;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } spiStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_INSTR, ST_DATA, ST_DONE} spiState_t;
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkPin,
  input  logic csNPin,
  input  logic sdioPin,
  output logic sclkRise,
  output logic sclkFall,
  output logic csHigh,
  output logic sdioBit
);
  logic [STAGES:0]   sclkPipe;
  logic [STAGES-1:0] csPipe;
  logic [STAGES-1:0] sdioPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      sdioPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[STAGES-1:0], sclkPin};
      csPipe   <= {csPipe[STAGES-2:0], csNPin};
      sdioPipe <= {sdioPipe[STAGES-2:0], sdioPin};
    end
  end

  assign sclkRise = sclkPipe[STAGES-1] & ~sclkPipe[STAGES];
  assign sclkFall = ~sclkPipe[STAGES-1] & sclkPipe[STAGES];
  assign csHigh   = csPipe[STAGES-1];
  assign sdioBit  = sdioPipe[STAGES-1];
endmodule

// File: rtl/spi3_ctrl.sv
module spi3_ctrl
  import spi3_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkRise,
  input  logic              sclkFall,
  input  logic              csHigh,
  input  logic              sdioBit,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] curAddr,
  output spiStrobe_t        strobe,
  output logic              isRead,
  output logic              sdioOut,
  output logic              sdioOe
);
  localparam int CNT_W = $clog2(INSTR_W);

  spiState_t          state;
  logic [INSTR_W-1:0] shiftIn;
  logic [CNT_W-1:0]   bitCnt;
  logic [1:0]         lenCode;
  logic [1:0]         byteIdx;
  logic [DATA_W-1:0]  txReg;

  wire lastInstrBit = (bitCnt == CNT_W'(INSTR_W - 1));
  wire lastDataBit  = (bitCnt == CNT_W'(DATA_W - 1));
  wire streaming    = (lenCode == 2'b11);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      shiftIn <= '0;
      bitCnt  <= '0;
      lenCode <= '0;
      byteIdx <= '0;
      txReg   <= '0;
      curAddr <= '0;
      isRead  <= 1'b0;
      sdioOe  <= 1'b0;
      strobe  <= '0;
    end else begin
      strobe.wrEn <= 1'b0;
      if (csHigh) begin
        state  <= ST_IDLE;
        sdioOe <= 1'b0;
        bitCnt <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            state   <= ST_INSTR;
            bitCnt  <= '0;
            byteIdx <= '0;
          end
          ST_INSTR: if (sclkRise) begin
            shiftIn <= {shiftIn[INSTR_W-2:0], sdioBit};
            if (lastInstrBit) begin
              isRead  <= shiftIn[INSTR_W-2];
              lenCode <= shiftIn[INSTR_W-3:INSTR_W-4];
              curAddr <= {shiftIn[ADDR_W-2:0], sdioBit};
              bitCnt  <= '0;
              state   <= ST_DATA;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (sclkFall && isRead) begin
              sdioOe <= 1'b1;
              if (bitCnt == '0) txReg <= rdData;
              else              txReg <= {txReg[DATA_W-2:0], 1'b0};
            end
            if (sclkRise) begin
              shiftIn <= {shiftIn[INSTR_W-2:0], sdioBit};
              if (lastDataBit) begin
                bitCnt <= '0;
                if (!isRead) begin
                  strobe.wrEn <= 1'b1;
                  strobe.addr <= curAddr;
                  strobe.data <= {shiftIn[DATA_W-2:0], sdioBit};
                end
                curAddr <= curAddr + 1'b1;
                if (!streaming && byteIdx == lenCode) state <= ST_DONE;
                else                                  byteIdx <= byteIdx + 1'b1;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdioOut = txReg[DATA_W-1];
endmodule

// File: rtl/spi3_regs.sv
module spi3_regs
  import spi3_pkg::*;
#(
  parameter int         NUM_REGS  = 7,
  parameter logic [1:0] IDX_RESET = 2'b11
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  spiStrobe_t               strobe,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [DATA_W-1:0]        rdData,
  output logic [1:0]               chanIdx,
  output logic [NUM_REGS*DATA_W-1:0] regFileA,
  output logic [NUM_REGS*DATA_W-1:0] regFileB
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int N_CH  = 2;

  wire             wrInRange = (strobe.addr != '0) && (strobe.addr <= ADDR_W'(NUM_REGS));
  wire [IDX_W-1:0] wrIdx     = IDX_W'(strobe.addr - ADDR_W'(1));
  wire             rdInRange = (rdAddr != '0) && (rdAddr <= ADDR_W'(NUM_REGS));
  wire [IDX_W-1:0] rdIdx     = IDX_W'(rdAddr - ADDR_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               chanIdx <= IDX_RESET;
    else if (strobe.wrEn && strobe.addr == '0) chanIdx <= strobe.data[1:0];
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : chanBank
    logic [DATA_W-1:0]          bank [NUM_REGS];
    logic [NUM_REGS*DATA_W-1:0] flatOut;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < NUM_REGS; k++) bank[k] <= '0;
      end else if (strobe.wrEn && wrInRange && chanIdx[ch]) begin
        bank[wrIdx] <= strobe.data;
      end
    end

    always_comb begin
      for (int k = 0; k < NUM_REGS; k++) flatOut[k*DATA_W +: DATA_W] = bank[k];
    end
  end

  assign regFileA = chanBank[0].flatOut;
  assign regFileB = chanBank[1].flatOut;

  always_comb begin
    if (rdAddr == '0)   rdData = {{(DATA_W-2){1'b0}}, chanIdx};
    else if (rdInRange) rdData = chanBank[0].bank[rdIdx];
    else                rdData = '0;
  end
endmodule

// File: rtl/dual_chan_spi_regs.sv
module dual_chan_spi_regs
  import spi3_pkg::*;
#(
  parameter int NUM_REGS    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclk,
  input  logic                       csN,
  input  logic                       sdioIn,
  output logic                       sdioOut,
  output logic                       sdioOe,
  output logic [NUM_REGS*DATA_W-1:0] regFileA,
  output logic [NUM_REGS*DATA_W-1:0] regFileB
);
  logic              sclkRise, sclkFall, csHigh, sdioBit, isRead;
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] rdData;
  logic [1:0]        chanIdx;
  spiStrobe_t        strobe;

  spi3_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclkPin(sclk), .csNPin(csN), .sdioPin(sdioIn),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csHigh(csHigh), .sdioBit(sdioBit)
  );

  spi3_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csHigh(csHigh), .sdioBit(sdioBit), .rdData(rdData), .curAddr(curAddr),
    .strobe(strobe), .isRead(isRead), .sdioOut(sdioOut), .sdioOe(sdioOe)
  );

  spi3_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdAddr(curAddr), .rdData(rdData),
    .chanIdx(chanIdx), .regFileA(regFileA), .regFileB(regFileB)
  );
endmodule

// File: rtl/spi3_checker.sv
module spi3_checker
  import spi3_pkg::*;
#(
  parameter int NUM_REGS = 7
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       csHigh,
  input logic                       sdioOe,
  input logic                       isRead,
  input spiStrobe_t                 strobe,
  input logic [1:0]                 chanIdx,
  input logic [NUM_REGS*DATA_W-1:0] regFileA,
  input logic [NUM_REGS*DATA_W-1:0] regFileB
);
  assert_oe_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> !sdioOe);

  assert_oe_read_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    sdioOe |-> isRead);

  assert_no_write_in_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> !isRead);

  assert_bank_a_masked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !chanIdx[0]) |=> $stable(regFileA));

  assert_bank_b_masked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !chanIdx[1]) |=> $stable(regFileB));

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> !strobe.wrEn);

  assert_idle_banks_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> ($stable(regFileA) && $stable(regFileB)));
endmodule

bind dual_chan_spi_regs spi3_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .csHigh(csHigh), .sdioOe(sdioOe), .isRead(isRead),
  .strobe(strobe), .chanIdx(chanIdx), .regFileA(regFileA), .regFileB(regFileB)
);

// File: tb/tb_dual_chan_spi_regs.sv
module tb_dual_chan_spi_regs;
  localparam int NREG = 7;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, sdioDrv = 1'b0;
  logic sdioOut, sdioOe;
  logic [NREG*8-1:0] regFileA, regFileB;

  int checks = 0, errors = 0;
  logic [7:0] mA [1:NREG];
  logic [7:0] mB [1:NREG];
  logic [1:0] mIdx = 2'b11;
  logic [7:0] txData [8];
  logic [7:0] expQ [$];
  logic [7:0] monByte = '0;
  int monCnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_chan_spi_regs #(.NUM_REGS(NREG)) dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdioIn(sdioDrv),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .regFileA(regFileA), .regFileB(regFileB)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: collects driven read bits on SCLK rise and pops expectations.
  always @(posedge sclk) begin
    if (!csN && sdioOe) begin
      monByte = {monByte[6:0], sdioOut};
      monCnt++;
      if (monCnt == 8) begin
        monCnt = 0;
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R7 actual=%0h expected=none", monByte);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          if (monByte !== e) begin
            errors++;
            $display("FAIL R7 actual=%0h expected=%0h", monByte, e);
          end
        end
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclkBit(input logic b, input bit probeOe);
    @(negedge clk) sdioDrv = b;
    waitClk(HALF);
    sclk = 1'b1;
    waitClk(HALF);
    if (probeOe) check("R8 oe low before turnaround", sdioOe, 0);
    sclk = 1'b0;
  endtask

  function automatic logic [7:0] modelRead(input int a);
    if (a == 0) return {6'b0, mIdx};
    if (a <= NREG) return mA[a];
    return 8'h00;
  endfunction

  task automatic modelApply(input bit rw, input logic [1:0] len, input int addr, input int n);
    for (int i = 0; i < n; i++) begin
      int a;
      if (len != 2'b11 && i > int'(len)) break;
      a = (addr + i) % 8192;
      if (rw) expQ.push_back(modelRead(a));
      else if (a == 0) mIdx = txData[i][1:0];
      else if (a <= NREG) begin
        if (mIdx[0]) mA[a] = txData[i];
        if (mIdx[1]) mB[a] = txData[i];
      end
    end
  endtask

  // Driver: full transaction, optional trailing partial bits.
  task automatic xfer(input bit rw, input logic [1:0] len, input logic [12:0] addr,
                      input int nBytes, input int extraBits);
    logic [15:0] instr;
    instr = {rw, len, addr};
    modelApply(rw, len, int'(addr), nBytes);
    csN = 1'b0;
    waitClk(HALF);
    for (int i = 15; i >= 0; i--) sclkBit(instr[i], rw && i == 0);
    for (int b = 0; b < nBytes; b++)
      for (int i = 7; i >= 0; i--) sclkBit(rw ? 1'b0 : txData[b][i], 1'b0);
    for (int i = 0; i < extraBits; i++) sclkBit(1'b1, 1'b0);
    waitClk(HALF);
    if (rw) check("R8 oe high during read", sdioOe, 1);
    csN = 1'b1;
    waitClk(2 * HALF);
    check("R8 oe released after cs", sdioOe, 0);
  endtask

  task automatic checkRegs(input string tag);
    for (int a = 1; a <= NREG; a++) begin
      check({tag, " bankA"}, regFileA[(a-1)*8 +: 8], mA[a]);
      check({tag, " bankB"}, regFileB[(a-1)*8 +: 8], mB[a]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 1; a <= NREG; a++) begin mA[a] = '0; mB[a] = '0; end
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    check("R1 oe after reset", sdioOe, 0);
    checkRegs("R1");
    xfer(1'b1, 2'b00, 13'd0, 1, 0);                        // R1 steering reads 03

    txData[0] = 8'hA5; xfer(1'b0, 2'b00, 13'd3, 1, 0);     // R2 R3 broadcast
    checkRegs("R3");

    txData[0] = 8'h01; xfer(1'b0, 2'b00, 13'd0, 1, 0);     // R4 select A
    txData[0] = 8'h3C; xfer(1'b0, 2'b00, 13'd2, 1, 0);
    checkRegs("R4");
    txData[0] = 8'h02; xfer(1'b0, 2'b00, 13'd0, 1, 0);     // R4 select B from A-only
    xfer(1'b1, 2'b00, 13'd0, 1, 0);
    txData[0] = 8'h11; txData[1] = 8'h22; txData[2] = 8'h33;
    xfer(1'b0, 2'b10, 13'd4, 3, 0);                        // R5 burst to B
    checkRegs("R5");

    txData[0] = 8'h03; xfer(1'b0, 2'b00, 13'd0, 1, 0);
    txData[0] = 8'h77; txData[1] = 8'h88; txData[2] = 8'h99;
    xfer(1'b0, 2'b00, 13'd1, 2, 0);                        // R6 one byte only
    xfer(1'b0, 2'b01, 13'd5, 3, 0);                        // R6 two bytes only
    checkRegs("R6 limit");
    for (int i = 0; i < 5; i++) txData[i] = 8'hC0 + 8'(i);
    xfer(1'b0, 2'b11, 13'd3, 5, 0);                        // R6 streaming
    checkRegs("R6 stream");

    txData[0] = 8'hDE; txData[1] = 8'hAD;
    xfer(1'b0, 2'b01, 13'd8, 2, 0);                        // R10 out of range
    checkRegs("R10");

    txData[0] = 8'h5A; xfer(1'b0, 2'b01, 13'd2, 1, 5);     // R9 partial byte
    checkRegs("R9 byte");
    csN = 1'b0; waitClk(HALF);                             // R9 partial instruction
    for (int i = 0; i < 10; i++) sclkBit(1'b0, 1'b0);
    waitClk(HALF); csN = 1'b1; waitClk(2 * HALF);
    checkRegs("R9 instr");

    txData[0] = 8'h01; xfer(1'b0, 2'b00, 13'd0, 1, 0);
    txData[0] = 8'hEE; xfer(1'b0, 2'b00, 13'd6, 1, 0);     // banks now differ
    checkRegs("R7 setup");
    xfer(1'b1, 2'b10, 13'd5, 3, 0);                        // R7 read from A
    xfer(1'b1, 2'b11, 13'd6, 3, 0);                        // R7 past end reads 0
    waitClk(4);
    check("R7 all reads seen", expQ.size(), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule